// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus: an active-high address latch strobe and an active-low code-fetch read strobe. It runs from the oscillator clock and walks a machine cycle of twelve clock states. Both strobes are derived from the current state and from a cycle context. The context captures whether code is executing from external memory, whether the cycle is an external data access, and which instruction class is active. It is sampled once per machine cycle.

The latch strobe fires twice per machine cycle, which is one sixth of the oscillator rate. During an external data access cycle, the second latch pulse and both read pulses are withheld. A one-bit control register, written through a small address/bit write port, can silence the latch strobe. In that state the pin is flagged for a weak pull-up instead of being driven. The strobe is still released for data-move and code-table-read instructions, and it is always released while code runs from external memory. All pins are plain level controls and carry no handshake. The address and data drivers belong to neighbouring logic.

Top module: `bus_strobe_gen`

## Requirements
- R1: Reset sets the machine cycle state to 0 and then advances it by one per clock, wrapping from 11 back to 0. In the first clock after reset is released the design is in state 1, so `ale` is high.
- R2: In a cycle with no data access and the latch strobe allowed, `ale` is high in states 0, 1, 6 and 7 and low otherwise. This gives two pulses of two clocks each per 12 clocks.
- R3: In a data access cycle, the pulse in states 6 and 7 is withheld and the pulse in states 0 and 1 is kept. Exactly one latch pulse is dropped.
- R4: In an external execution cycle with no data access, `psen_n` is low in states 2, 3, 4, 8, 9 and 10 and high otherwise.
- R5: In a data access cycle, `psen_n` stays high for all 12 states. Both read pulses are dropped.
- R6: In an internal execution cycle, `psen_n` stays high.
- R7: A write with `cfg_wr`=1 and `cfg_addr`=8'h8E loads `cfg_bit` into the latch-disable bit. A write to any other address leaves the bit unchanged. Reset clears the bit to 0.
- R8: When the disable bit is 1, execution is internal and the instruction class is "other" (code 2'b00 or 2'b11), `ale` stays low and `ale_weak` is high for the whole cycle.
- R9: With the disable bit at 1, instruction class 2'b01 (data move) or 2'b10 (code-table read) restores the R2/R3 latch pattern, with `ale_weak` low.
- R10: With the disable bit at 1, external execution restores the R2/R3 latch pattern, with `ale_weak` low.
- R11: `ext_exec`, `xdata_cycle` and `instr_class` are sampled on the clock edge that leaves state 11. They govern the whole following machine cycle. After reset they are taken as 0 until the first sample.
- R12: `ale` and `ale_weak` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_exec | input | 1 | Code is fetched from external memory |
| xdata_cycle | input | 1 | Coming machine cycle is an external data access |
| instr_class | input | 2 | 00 other, 01 data move, 10 code-table read, 11 other |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_addr | input | 8 | Control register write address |
| cfg_bit | input | 1 | Value written to the latch-disable bit |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code read strobe, active low |
| ale_weak | output | 1 | Latch pin released to weak pull-up |

## Verification
A phase counter that skips or repeats a state moves every later pulse edge. That error shows at the ports on the next strobe boundary, within at most 12 clocks. A wrong latched context shows within one machine cycle, as a missing or extra pulse: a data access flag leaking into the next cycle, or an execution flag taken at the wrong state. A stale or mis-decoded disable bit shows as `ale_weak` toggling against the configured value on the next cycle that has class "other". The bench compares all three outputs on every clock against a cycle model, so these faults are caught in the cycle where they first appear.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER   = 2'b00,
    CLS_DMOVE   = 2'b01,
    CLS_CTABLE  = 2'b10,
    CLS_OTHER2  = 2'b11
  } instr_cls_e;

  typedef struct packed {
    logic       ext;
    logic       xdata;
    instr_cls_e cls;
  } cyc_ctx_t;

  function automatic logic cls_forces_ale(instr_cls_e c);
    return (c == CLS_DMOVE) || (c == CLS_CTABLE);
  endfunction
endpackage

// File: rtl/bus_strobe_phase.sv
module bus_strobe_phase #(
  parameter int CYC_LEN = 12,
  localparam int PH_W = $clog2(CYC_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            last
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYC_LEN - 1);

  assign last = (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= '0;
    else if (last) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/bus_strobe_ctx.sv
module bus_strobe_ctx
  import bus_strobe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample,
  input  logic       ext_in,
  input  logic       xdata_in,
  input  logic [1:0] cls_in,
  output cyc_ctx_t   ctx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx <= '{ext: 1'b0, xdata: 1'b0, cls: CLS_OTHER};
    end else if (sample) begin
      ctx.ext   <= ext_in;
      ctx.xdata <= xdata_in;
      ctx.cls   <= instr_cls_e'(cls_in);
    end
  end
endmodule

// File: rtl/bus_strobe_cfg.sv
module bus_strobe_cfg #(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit,
  output logic              ale_off
);
  logic hit;
  assign hit = wr && (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ale_off <= 1'b0;
    else if (hit) ale_off <= wbit;
  end
endmodule

// File: rtl/bus_strobe_window.sv
module bus_strobe_window #(
  parameter int CYC_LEN = 12,
  parameter int START   = 0,
  parameter int WIDTH   = 2,
  localparam int PH_W   = $clog2(CYC_LEN)
) (
  input  logic [PH_W-1:0] phase,
  output logic            hit
);
  localparam int          STOP  = START + WIDTH;
  localparam logic [PH_W:0] HI  = (PH_W+1)'(STOP);
  localparam logic [PH_W:0] LO  = (PH_W+1)'(START);

  logic [PH_W:0] ph_ext;
  assign ph_ext = {1'b0, phase};

  generate
    if (START == 0) begin : g_from_zero
      assign hit = (ph_ext < HI);
    end else begin : g_mid
      assign hit = (ph_ext >= LO) && (ph_ext < HI);
    end
  endgenerate
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int CYC_LEN     = 12,
  parameter int ALE_WIDTH   = 2,
  parameter int ALE_KEEP_AT = 0,
  parameter int ALE_SKIP_AT = 6,
  parameter int PSEN_WIDTH  = 3,
  parameter int PSEN_SLOTS  = 2,
  parameter int PSEN_AT0    = 2,
  parameter int PSEN_STEP   = 6,
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] DIS_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_exec,
  input  logic              xdata_cycle,
  input  logic [1:0]        instr_class,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_bit,
  output logic              ale,
  output logic              psen_n,
  output logic              ale_weak
);
  localparam int PH_W = $clog2(CYC_LEN);

  logic [PH_W-1:0] phase;
  logic            phase_last;
  cyc_ctx_t        ctx;
  logic            ale_off;
  logic            cyc_ext;
  logic            cyc_data;

  bus_strobe_phase #(.CYC_LEN(CYC_LEN)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last(phase_last)
  );

  bus_strobe_ctx u_ctx (
    .clk(clk), .rst_n(rst_n), .sample(phase_last),
    .ext_in(ext_exec), .xdata_in(xdata_cycle), .cls_in(instr_class),
    .ctx(ctx)
  );

  bus_strobe_cfg #(.ADDR_W(ADDR_W), .REG_ADDR(DIS_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
    .wbit(cfg_bit), .ale_off(ale_off)
  );

  assign cyc_ext  = ctx.ext;
  assign cyc_data = ctx.xdata;

  // Latch strobe: one kept slot, one slot dropped in data-access cycles.
  logic ale_keep_hit, ale_skip_hit;

  bus_strobe_window #(.CYC_LEN(CYC_LEN), .START(ALE_KEEP_AT), .WIDTH(ALE_WIDTH))
    u_ale_keep (.phase(phase), .hit(ale_keep_hit));
  bus_strobe_window #(.CYC_LEN(CYC_LEN), .START(ALE_SKIP_AT), .WIDTH(ALE_WIDTH))
    u_ale_skip (.phase(phase), .hit(ale_skip_hit));

  logic ale_allowed;
  logic ale_pattern;

  always_comb begin
    ale_allowed = !ale_off || ctx.ext || cls_forces_ale(ctx.cls);
    ale_pattern = ale_keep_hit || (ale_skip_hit && !ctx.xdata);
  end

  assign ale      = ale_allowed && ale_pattern;
  assign ale_weak = !ale_allowed;

  // Code read strobe: repeated slots, all dropped in data-access cycles.
  logic [PSEN_SLOTS-1:0] psen_hits;

  generate
    for (genvar s = 0; s < PSEN_SLOTS; s++) begin : g_psen_slot
      bus_strobe_window #(
        .CYC_LEN(CYC_LEN),
        .START(PSEN_AT0 + s * PSEN_STEP),
        .WIDTH(PSEN_WIDTH)
      ) u_win (.phase(phase), .hit(psen_hits[s]));
    end
  endgenerate

  assign psen_n = !(ctx.ext && !ctx.xdata && (|psen_hits));
endmodule

// File: rtl/bus_strobe_chk.sv
module bus_strobe_chk #(
  parameter int CYC_LEN = 12,
  localparam int PH_W = $clog2(CYC_LEN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PH_W-1:0] phase,
  input logic            cyc_ext,
  input logic            cyc_data,
  input logic            ale,
  input logic            psen_n,
  input logic            ale_weak
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYC_LEN - 1);

  // R1: state wraps from the last state to 0
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == LAST_PH) |=> (phase == '0));

  // R2: every latch pulse lasts exactly two clocks
  p_ale_two_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale ##1 !ale);

  // R4: every read pulse lasts exactly three clocks
  p_psen_three_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);

  // R5: no read pulse inside a data-access cycle
  p_psen_quiet_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_data |-> psen_n);

  // R6: no read pulse while executing internally
  p_psen_quiet_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_ext |-> psen_n);

  // R10: external execution never releases the latch pin
  p_ext_no_weak_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ext |-> !ale_weak);

  // R12: driven pulse and weak release are exclusive
  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && ale_weak));
endmodule

bind bus_strobe_gen bus_strobe_chk #(.CYC_LEN(CYC_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .cyc_ext(cyc_ext),
  .cyc_data(cyc_data), .ale(ale), .psen_n(psen_n), .ale_weak(ale_weak)
);

// File: tb/tb_bus_strobe_gen.sv
module tb_bus_strobe_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [7:0] DIS_ADDR = 8'h8E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_exec = 1'b0;
  logic       xdata_cycle = 1'b0;
  logic [1:0] instr_class = 2'b00;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_addr = 8'h00;
  logic       cfg_bit = 1'b0;
  logic       ale, psen_n, ale_weak;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .ext_exec(ext_exec), .xdata_cycle(xdata_cycle),
    .instr_class(instr_class), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_bit(cfg_bit), .ale(ale), .psen_n(psen_n), .ale_weak(ale_weak)
  );

  // Cycle model built from the requirements
  int         m_ph;
  logic       m_ext, m_data, m_dis;
  logic [1:0] m_cls;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= 0; m_ext <= 0; m_data <= 0; m_cls <= 2'b00; m_dis <= 0;
    end else begin
      m_ph <= (m_ph == 11) ? 0 : m_ph + 1;
      if (m_ph == 11) begin
        m_ext <= ext_exec; m_data <= xdata_cycle; m_cls <= instr_class;
      end
      if (cfg_wr && cfg_addr == DIS_ADDR) m_dis <= cfg_bit;
    end
  end

  function automatic logic exp_allow();
    return !m_dis || m_ext || m_cls == 2'b01 || m_cls == 2'b10;
  endfunction

  function automatic logic exp_ale();
    return exp_allow() && (m_ph == 0 || m_ph == 1 ||
                           (!m_data && (m_ph == 6 || m_ph == 7)));
  endfunction

  function automatic logic exp_psen_n();
    return !(m_ext && !m_data && ((m_ph >= 2 && m_ph <= 4) ||
                                  (m_ph >= 8 && m_ph <= 10)));
  endfunction

  task automatic compare(input string tag);
    n_vec++;
    if (ale !== exp_ale() || psen_n !== exp_psen_n() || ale_weak !== !exp_allow()) begin
      n_bad++;
      $display("FAIL %s state=%0d ale/psen_n/weak actual=%b%b%b expected=%b%b%b",
               tag, m_ph, ale, psen_n, ale_weak, exp_ale(), exp_psen_n(), !exp_allow());
    end
    if (ale && ale_weak) begin
      n_bad++;
      $display("FAIL R12 ale/weak actual=11 expected=not both");
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic b, input string tag);
    cfg_wr = 1'b1; cfg_addr = a; cfg_bit = b;
    run(1, tag);
    cfg_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    run(1, "R1");                 // in reset: state 0
    rst_n = 1'b1;
    @(negedge clk);               // one edge after release: state 1
    n_vec++;
    if (ale !== 1'b1 || psen_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 ale/psen_n actual=%b%b expected=11", ale, psen_n);
    end
    run(22, "R1");
    // R2: internal, no data access
    run(24, "R2");
    // R3 + R5 with internal exec; context takes effect after state 11
    xdata_cycle = 1'b1;
    run(24, "R3");
    // R4: external code fetch
    xdata_cycle = 1'b0; ext_exec = 1'b1;
    run(24, "R4");
    // R5: external with data access
    xdata_cycle = 1'b1;
    run(24, "R5");
    // R6: back to internal
    xdata_cycle = 1'b0; ext_exec = 1'b0;
    run(24, "R6");
    // R7: wrong address is ignored, ALE keeps pulsing
    cfg_write(8'h8F, 1'b1, "R7");
    cfg_write(8'h0E, 1'b1, "R7");
    run(12, "R7");
    cfg_write(DIS_ADDR, 1'b1, "R7");
    // R8: silenced, class other (both encodings)
    run(24, "R8");
    instr_class = 2'b11;
    run(24, "R8");
    // R9: data move and code-table read restore the pulses
    instr_class = 2'b01;
    run(24, "R9");
    instr_class = 2'b10; xdata_cycle = 1'b1;
    run(24, "R9");
    // R10: external execution overrides the disable bit
    instr_class = 2'b00; xdata_cycle = 1'b0; ext_exec = 1'b1;
    run(24, "R10");
    // R11: inputs toggled mid-cycle must not affect the current cycle
    for (int k = 0; k < 40; k++) begin
      ext_exec = 1'($urandom); xdata_cycle = 1'($urandom);
      instr_class = 2'($urandom);
      run(1 + int'($urandom % 5), "R11");
    end
    // Random mix including config writes
    for (int k = 0; k < 300; k++) begin
      ext_exec = 1'($urandom); xdata_cycle = 1'($urandom);
      instr_class = 2'($urandom);
      if (($urandom % 8) == 0)
        cfg_write(($urandom % 2) ? DIS_ADDR : 8'($urandom), 1'($urandom), "R7");
      run(1 + int'($urandom % 7), "R11");
    end
    // R7: reset clears the disable bit
    cfg_write(DIS_ADDR, 1'b1, "R7");
    ext_exec = 1'b0; xdata_cycle = 1'b0; instr_class = 2'b00;
    rst_n = 1'b0;
    run(2, "R7");
    rst_n = 1'b1;
    run(24, "R7");
    finish_run();
  end
endmodule